// File: doc/BRIEF.md
# Reset Cause Flag Register

This block keeps a 16-bit word of sticky flags that tells firmware why the device last came out of reset or went into a low-power state. Each flag is set by a one-cycle event pulse from elsewhere in the chip. The events are:

- trap conflict
- illegal opcode
- configuration mismatch
- external reset pin
- software reset
- watchdog time-out
- brown-out
- power-on
- the power-save instruction, which can set one of three power-state flags

Most flags stay set until a power-on event. The watchdog flag is the exception. Software can also set or clear any implemented bit through a write port with a per-bit enable.

The block also picks the system clock source code when a reset event occurs. Power-on and brown-out events always take the code from the configuration oscillator field. Every other reset event keeps the running selection when clock switching is enabled, and falls back to the configuration field when it is not. The register and the clock selection both update on the clock edge that follows the event, so they have one cycle of latency.

Top module: `rst_cause_reg`

## Requirements
- R1: A pulse on an event input sets its flag on the next edge: trap conflict sets bit 15, illegal opcode bit 14, configuration mismatch bit 9, external pin bit 7, software reset bit 6 and watchdog time-out bit 4.
- R2: A power-on pulse, like the hardware reset, makes the register exactly 16'h0003 (bits 0 and 1 set) on the next edge, whatever else happens in that cycle.
- R3: A brown-out pulse on its own sets only bit 1.
- R4: The watchdog-clear pulse or any power-save pulse clears bit 4 unless a watchdog time-out arrives in the same cycle. Such a clear also overrides a software write to bit 4.
- R5: A power-save pulse with mode 0 sets bit 3 when deep-sleep enable is low and bit 10 when it is high. With mode 1 it sets bit 2.
- R6: Without a power-on event or a software write, set flags other than bit 4 never clear, including across the other reset events.
- R7: Software writes load wr_data into each bit whose wr_en bit is high and leave the other bits as they are.
- R8: When an event and a software write target the same bit in the same cycle, the event wins and the bit ends up set.
- R9: Bits 5, 8, 11, 12 and 13 always read zero and ignore writes.
- R10: A power-on or brown-out pulse loads the clock selection from cfg_osc on the next edge. The hardware reset does the same.
- R11: Any other reset event (trap, illegal opcode, mismatch, pin, software, watchdog) loads cur_osc when clk_sw_en is high and cfg_osc when it is low. Without a reset event the clock selection holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low hardware reset, gives the power-on state |
| ev_trap | input | 1 | Trap conflict pulse |
| ev_illop | input | 1 | Illegal opcode / uninitialized register pulse |
| ev_cfgmis | input | 1 | Configuration mismatch pulse |
| ev_pin | input | 1 | External reset pin pulse |
| ev_swrst | input | 1 | Software reset instruction pulse |
| ev_wdt | input | 1 | Watchdog time-out pulse |
| ev_bor | input | 1 | Brown-out pulse |
| ev_por | input | 1 | Power-on pulse |
| ps_exec | input | 1 | Power-save instruction pulse |
| ps_mode | input | 1 | Power-save mode: 0 sleep, 1 idle |
| dsleep_en | input | 1 | Deep-sleep enable |
| wdt_clr | input | 1 | Watchdog-clear instruction pulse |
| wr_en | input | 16 | Per-bit software write enable |
| wr_data | input | 16 | Software write data |
| clk_sw_en | input | 1 | Clock switching enabled |
| cfg_osc | input | OSC_W | Configuration oscillator field |
| cur_osc | input | OSC_W | Currently running clock selection |
| flags | output | 16 | Flag register |
| clk_sel | output | OSC_W | Clock source selected at reset |

## Verification
The bench builds the block with the default OSC_W of 3. With that width every clock-source code fits in a few random draws, and any pair of configuration and running codes can be told apart. Directed cycles exercise each event alone and each same-cycle conflict: an event against a write, a clear against a time-out, and a power-on against everything else. Both clock-switching settings are covered. A long run of sparse random events, writes and clock codes then compares both outputs against an arithmetic model after every cycle. That run reaches the combinations of simultaneous events across the full 16-bit write space.

// File: rtl/rst_cause_reg.sv
module rst_cause_reg #(
  parameter int OSC_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ev_trap,
  input  logic             ev_illop,
  input  logic             ev_cfgmis,
  input  logic             ev_pin,
  input  logic             ev_swrst,
  input  logic             ev_wdt,
  input  logic             ev_bor,
  input  logic             ev_por,
  input  logic             ps_exec,
  input  logic             ps_mode,
  input  logic             dsleep_en,
  input  logic             wdt_clr,
  input  logic [15:0]      wr_en,
  input  logic [15:0]      wr_data,
  input  logic             clk_sw_en,
  input  logic [OSC_W-1:0] cfg_osc,
  input  logic [OSC_W-1:0] cur_osc,
  output logic [15:0]      flags,
  output logic [OSC_W-1:0] clk_sel
);

  localparam int B_TRAP = 15, B_ILL = 14, B_DSL = 10, B_MIS = 9, B_PIN = 7;
  localparam int B_SW = 6, B_WDT = 4, B_SLP = 3, B_IDL = 2, B_BOR = 1, B_POR = 0;
  localparam logic [15:0] USED = 16'hC6DF;
  localparam logic [15:0] PON  = 16'h0003;

  logic [15:0] set_v, clr_v, wr_v, nxt;
  logic        warm_rst;

  always_comb begin
    set_v = '0;
    set_v[B_TRAP] = ev_trap;
    set_v[B_ILL]  = ev_illop;
    set_v[B_MIS]  = ev_cfgmis;
    set_v[B_PIN]  = ev_pin;
    set_v[B_SW]   = ev_swrst;
    set_v[B_WDT]  = ev_wdt;
    set_v[B_BOR]  = ev_bor;
    set_v[B_SLP]  = ps_exec & ~ps_mode & ~dsleep_en;
    set_v[B_DSL]  = ps_exec & ~ps_mode & dsleep_en;
    set_v[B_IDL]  = ps_exec & ps_mode;
    clr_v = '0;
    clr_v[B_WDT]  = wdt_clr | ps_exec;
  end

  assign wr_v     = (flags & ~wr_en) | (wr_data & wr_en);
  assign nxt      = ev_por ? PON : (((wr_v & ~clr_v) | set_v) & USED);
  assign warm_rst = ev_trap | ev_illop | ev_cfgmis | ev_pin | ev_swrst | ev_wdt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags   <= PON;
      clk_sel <= cfg_osc;
    end else begin
      flags <= nxt;
      if (ev_por || ev_bor)
        clk_sel <= cfg_osc;
      else if (warm_rst)
        clk_sel <= clk_sw_en ? cur_osc : cfg_osc;
    end
  end

  AST_PON_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    ev_por |=> flags == 16'h0003); // R2
  AST_BOR_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    ev_bor |=> flags[1]); // R3
  AST_WDT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (!ev_por && !ev_wdt && (wdt_clr || ps_exec)) |=> !flags[4]); // R4
  AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (!ev_por && wr_en == 16'h0 && !ps_exec && !wdt_clr) |=> ((flags & $past(flags)) == $past(flags))); // R6
  AST_EVENT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (!ev_por && ev_pin && wr_en[7] && !wr_data[7]) |=> flags[7]); // R8
  AST_UNUSED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (flags & 16'h3920) == 16'h0); // R9
  AST_CLK_COLD: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_por || ev_bor) |=> clk_sel == $past(cfg_osc)); // R10
  AST_CLK_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!ev_por && !ev_bor && ev_pin && clk_sw_en) |=> clk_sel == $past(cur_osc)); // R11

endmodule

// File: tb/rst_cause_reg_tb.sv
module rst_cause_reg_tb;
  localparam int CLK_PERIOD = 10;
  localparam int OSC_W = 3;
  localparam logic [15:0] USED = 16'hC6DF;

  logic clk = 0, rst_n = 0;
  logic ev_trap, ev_illop, ev_cfgmis, ev_pin, ev_swrst, ev_wdt, ev_bor, ev_por;
  logic ps_exec, ps_mode, dsleep_en, wdt_clr, clk_sw_en;
  logic [15:0] wr_en, wr_data, flags;
  logic [OSC_W-1:0] cfg_osc, cur_osc, clk_sel;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [15:0] e_flags;
  logic [OSC_W-1:0] e_osc;

  always #(CLK_PERIOD/2) clk = ~clk;

  rst_cause_reg #(.OSC_W(OSC_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .ev_trap(ev_trap), .ev_illop(ev_illop),
    .ev_cfgmis(ev_cfgmis), .ev_pin(ev_pin), .ev_swrst(ev_swrst), .ev_wdt(ev_wdt),
    .ev_bor(ev_bor), .ev_por(ev_por), .ps_exec(ps_exec), .ps_mode(ps_mode),
    .dsleep_en(dsleep_en), .wdt_clr(wdt_clr), .wr_en(wr_en), .wr_data(wr_data),
    .clk_sw_en(clk_sw_en), .cfg_osc(cfg_osc), .cur_osc(cur_osc),
    .flags(flags), .clk_sel(clk_sel));

  task automatic quiet();
    {ev_trap, ev_illop, ev_cfgmis, ev_pin, ev_swrst, ev_wdt, ev_bor, ev_por} = '0;
    {ps_exec, ps_mode, dsleep_en, wdt_clr} = '0;
    wr_en = '0; wr_data = '0;
  endtask

  task automatic model();
    logic [15:0] n;
    if (ev_por) begin
      e_flags = 16'h0003; e_osc = cfg_osc;
    end else begin
      n = (e_flags & ~wr_en) | (wr_data & wr_en);
      if (wdt_clr || ps_exec) n[4] = 1'b0;
      if (ev_trap) n[15] = 1'b1;
      if (ev_illop) n[14] = 1'b1;
      if (ev_cfgmis) n[9] = 1'b1;
      if (ev_pin) n[7] = 1'b1;
      if (ev_swrst) n[6] = 1'b1;
      if (ev_wdt) n[4] = 1'b1;
      if (ev_bor) n[1] = 1'b1;
      if (ps_exec && !ps_mode && !dsleep_en) n[3] = 1'b1;
      if (ps_exec && !ps_mode && dsleep_en) n[10] = 1'b1;
      if (ps_exec && ps_mode) n[2] = 1'b1;
      e_flags = n & USED;
      if (ev_bor) e_osc = cfg_osc;
      else if (ev_trap || ev_illop || ev_cfgmis || ev_pin || ev_swrst || ev_wdt)
        e_osc = clk_sw_en ? cur_osc : cfg_osc;
    end
  endtask

  task automatic compare(string tag);
    checks++;
    if (flags !== e_flags) begin
      errors++;
      $display("FAIL %s flags actual %h expected %h", tag, flags, e_flags);
    end
    checks++;
    if (clk_sel !== e_osc) begin
      errors++;
      $display("FAIL %s clk_sel actual %0d expected %0d", tag, clk_sel, e_osc);
    end
  endtask

  task automatic cycle(string tag);
    model();
    @(posedge clk);
    @(negedge clk);
    compare(tag);
    quiet();
  endtask

  initial begin
    quiet();
    clk_sw_en = 1; cfg_osc = 3'd5; cur_osc = 3'd1;
    e_flags = 16'h0003; e_osc = 3'd5;
    repeat (3) @(negedge clk);
    compare("R2 reset");
    rst_n = 1;
    @(negedge clk);
    compare("R2 after release");

    wr_en = 16'hFFFF; wr_data = 16'hFFFF; cycle("R9 write ones");
    checks++;
    if (flags !== 16'hC6DF) begin errors++; $display("FAIL R9 actual %h expected c6df", flags); end
    wr_en = 16'hFFFF; wr_data = 16'h0000; cycle("R7 write zeros");
    wr_en = 16'h00F0; wr_data = 16'hAAAA; cycle("R7 partial write");
    wr_en = 16'hFFFF; cycle("R7 clear");

    ev_trap = 1; cycle("R1 trap");
    ev_illop = 1; cycle("R1 illop");
    ev_cfgmis = 1; cycle("R1 mismatch");
    ev_pin = 1; cycle("R1 pin");
    ev_swrst = 1; cycle("R1 swrst");
    ev_wdt = 1; cycle("R1 wdt");
    checks++;
    if (flags !== 16'hC2D0) begin errors++; $display("FAIL R1 actual %h expected c2d0", flags); end
    ev_pin = 1; ev_swrst = 1; cycle("R6 sticky under resets");

    wr_en = 16'hFFFF; cycle("R7 clear");
    ev_bor = 1; cycle("R3 brownout");
    checks++;
    if (flags !== 16'h0002) begin errors++; $display("FAIL R3 actual %h expected 0002", flags); end

    ps_exec = 1; cycle("R5 sleep");
    ps_exec = 1; dsleep_en = 1; cycle("R5 deep sleep");
    ps_exec = 1; ps_mode = 1; cycle("R5 idle");

    ev_wdt = 1; cycle("R1 wdt");
    wdt_clr = 1; cycle("R4 wdt clear");
    ev_wdt = 1; cycle("R1 wdt");
    ps_exec = 1; ps_mode = 1; cycle("R4 powersave clears");
    ev_wdt = 1; wdt_clr = 1; cycle("R4 timeout beats clear");
    wdt_clr = 1; wr_en = 16'h0010; wr_data = 16'h0010; cycle("R4 clear beats write");

    ev_pin = 1; wr_en = 16'h0080; wr_data = 16'h0000; cycle("R8 event beats write");

    cur_osc = 3'd6; cfg_osc = 3'd2; clk_sw_en = 1;
    ev_pin = 1; cycle("R11 keep running");
    cycle("R11 hold");
    ev_bor = 1; cycle("R10 brownout config");
    cur_osc = 3'd7; ev_wdt = 1; cycle("R11 watchdog keep");
    clk_sw_en = 0; ev_swrst = 1; cycle("R11 switching off");
    clk_sw_en = 1; cur_osc = 3'd4; ev_por = 1; ev_trap = 1; wr_en = 16'hFFFF; wr_data = 16'hFFFF;
    cycle("R2 por priority");
    cfg_osc = 3'd3; ev_por = 1; cycle("R10 por config");

    for (int i = 0; i < 4000; i++) begin
      ev_trap   = ($urandom % 16) == 0;
      ev_illop  = ($urandom % 16) == 0;
      ev_cfgmis = ($urandom % 16) == 0;
      ev_pin    = ($urandom % 16) == 0;
      ev_swrst  = ($urandom % 16) == 0;
      ev_wdt    = ($urandom % 8) == 0;
      ev_bor    = ($urandom % 32) == 0;
      ev_por    = ($urandom % 64) == 0;
      ps_exec   = ($urandom % 8) == 0;
      ps_mode   = $urandom % 2;
      dsleep_en = $urandom % 2;
      wdt_clr   = ($urandom % 8) == 0;
      wr_en     = (($urandom % 4) == 0) ? 16'($urandom) : 16'h0;
      wr_data   = 16'($urandom);
      clk_sw_en = $urandom % 2;
      cfg_osc   = 3'($urandom);
      cur_osc   = 3'($urandom);
      cycle("R6 random model");
    end

    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule